// File: doc/BRIEF.md
# Sample FIFO with Ready Threshold

This block buffers conversion results for one acquisition channel. A converter pushes a sample with a one-cycle write strobe, and software or a DMA engine pops samples through a data-port read. The block keeps a live fill count. It compares that count with a programmable threshold to decide when enough data is waiting. It also records sticky overflow and underflow status, and it offers a flush control that empties the store in one write.

The channel number is a parameter, and it fixes the depth. Channels 0 and 1 hold 64 samples and every other channel holds 8. The count, threshold, status and flush live in one control word. A second word holds two interrupt flags (data ready, FIFO error), which are cleared by writing 1, together with their enables. A DMA request line is armed through a set strobe and disarmed through a separate clear strobe. It asserts while armed and the ready condition holds.

Top module: `smp_fifo`

## Requirements
- R1: The fill count reads in control-word bits 30:24. It equals the number of stored samples, never exceeds the depth, and resets to 0.
- R2: The ready threshold reads and writes in control-word bits 15:8 and resets to 1. Every control write loads it.
- R3: A sample that arrives while the store is full, with no read in the same cycle, is dropped, and sticky overflow (control bit 17) sets.
- R4: A data-port read of an empty store returns 0, and sticky underflow (control bit 18) sets.
- R5: Reads return samples oldest first. rd_data changes on the clock edge that accepts rd_en and holds otherwise.
- R6: The data-ready flag (interrupt-word bit 16) sets on the edge after a cycle in which count is nonzero and count ≥ threshold. Writing 1 to bit 16 clears it, but a set in the same cycle wins.
- R7: The error flag (interrupt-word bit 17) sets on any overflow or underflow event. Writing 1 to bit 17 clears it, but an event in the same cycle wins. A flush does not clear it.
- R8: Interrupt enables sit in interrupt-word bits 0 (ready) and 1 (error). irq is the OR of each flag ANDed with its enable.
- R9: dma_req is high while the request is armed and the ready condition of R6 holds. dma_set arms, dma_clr disarms, and set wins when both arrive together.
- R10: A control write with bit 0 set empties the store and clears overflow and underflow. A sample or read in the same cycle is discarded, and such a read returns 0. Bit 0 always reads 0.
- R11: Depth is 64 when CHAN_ID is 0 or 1, and 8 otherwise.
- R12: A sample and a read in the same cycle at a full store are both carried out. The count stays at the depth and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Sample write strobe |
| smp_data | input | DATA_W | Sample value |
| rd_en | input | 1 | Data-port read strobe |
| rd_data | output | DATA_W | Sample returned by the last read |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control-word write value (threshold 15:8, flush 0) |
| ctl_rdata | output | 32 | Control word: count 30:24, underflow 18, overflow 17, threshold 15:8 |
| int_wr | input | 1 | Interrupt-word write strobe |
| int_wdata | input | 32 | Enables 1:0; write 1 to bits 17/16 to clear the flags |
| int_rdata | output | 32 | Flags 17:16, enables 1:0 |
| irq | output | 1 | Combined interrupt |
| dma_set | input | 1 | Arm the DMA request |
| dma_clr | input | 1 | Disarm the DMA request |
| dma_req | output | 1 | DMA request |

## Verification
Several functions can land on the same edge, and the bench provokes each collision on purpose. It writes and reads together at a full store and at an empty store. It issues a flush alongside a sample strobe. It clears a flag by writing 1 while that flag's set condition still holds. It pulses arm and disarm together. A behavioural queue model applies the stated priorities on every clock: pop before push, flush over both, set over clear. Its count, status, flags, read data and request are compared with the design each cycle, on a 64-deep and an 8-deep instance driven in parallel.

// File: rtl/smpf_pkg.sv
package smpf_pkg;
  localparam int DEEP_DEPTH    = 64;
  localparam int SHALLOW_DEPTH = 8;
  localparam int THR_W         = 8;
  localparam int CNT_FW        = 7;
  // control word field positions
  localparam int CNT_LSB   = 24;
  localparam int CNT_MSB   = 30;
  localparam int UF_BIT    = 18;
  localparam int OF_BIT    = 17;
  localparam int THR_LSB   = 8;
  localparam int THR_MSB   = 15;
  localparam int FLUSH_BIT = 0;
  // interrupt word field positions
  localparam int ERR_FLG = 17;
  localparam int RDY_FLG = 16;
  localparam int ERR_IE  = 1;
  localparam int RDY_IE  = 0;

  function automatic int fifo_depth(input int ch);
    return (ch < 2) ? DEEP_DEPTH : SHALLOW_DEPTH;
  endfunction
endpackage

// File: rtl/smpf_store.sv
module smpf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  cnt,
  output logic              full,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = bump(wr_ptr_q);
      if (pop)  rd_ptr_d = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= wdata;
  end

  assign head  = mem[rd_ptr_q];
  assign cnt   = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/smpf_stat.sv
module smpf_stat #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [THR_W-1:0]  cfg_thr,
  input  logic              flush,
  input  logic              ovf_evt,
  input  logic              udf_evt,
  input  logic              rd_en,
  input  logic              pop,
  input  logic [DATA_W-1:0] head,
  output logic [THR_W-1:0]  thr,
  output logic              of_st,
  output logic              uf_st,
  output logic [DATA_W-1:0] rd_data
);
  logic [THR_W-1:0]  thr_q, thr_d;
  logic              of_q, of_d, uf_q, uf_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;

  always_comb begin
    thr_d = cfg_wr ? cfg_thr : thr_q;
    if (flush) begin
      of_d = 1'b0;
      uf_d = 1'b0;
    end else begin
      of_d = of_q | ovf_evt;
      uf_d = uf_q | udf_evt;
    end
    rdd_d = rdd_q;
    if (rd_en) rdd_d = pop ? head : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_W'(1);
      of_q  <= 1'b0;
      uf_q  <= 1'b0;
      rdd_q <= '0;
    end else begin
      thr_q <= thr_d;
      of_q  <= of_d;
      uf_q  <= uf_d;
      rdd_q <= rdd_d;
    end
  end

  assign thr     = thr_q;
  assign of_st   = of_q;
  assign uf_st   = uf_q;
  assign rd_data = rdd_q;
endmodule

// File: rtl/smpf_flags.sv
module smpf_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_cond,
  input  logic       err_evt,
  input  logic       clr_rdy,
  input  logic       clr_err,
  input  logic       ie_wr,
  input  logic [1:0] ie_val,
  input  logic       arm_set,
  input  logic       arm_clr,
  output logic       rdy_flag,
  output logic       err_flag,
  output logic [1:0] ie,
  output logic       armed
);
  logic       rdy_q, rdy_d, err_q, err_d, arm_q, arm_d;
  logic [1:0] ie_q, ie_d;

  always_comb begin
    rdy_d = ready_cond | (rdy_q & ~clr_rdy);
    err_d = err_evt | (err_q & ~clr_err);
    ie_d  = ie_wr ? ie_val : ie_q;
    arm_d = arm_q;
    if (arm_set)      arm_d = 1'b1;
    else if (arm_clr) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      ie_q  <= '0;
      arm_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      err_q <= err_d;
      ie_q  <= ie_d;
      arm_q <= arm_d;
    end
  end

  assign rdy_flag = rdy_q;
  assign err_flag = err_q;
  assign ie       = ie_q;
  assign armed    = arm_q;
endmodule

// File: rtl/smp_fifo.sv
module smp_fifo
  import smpf_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              int_wr,
  input  logic [31:0]       int_wdata,
  output logic [31:0]       int_rdata,
  output logic              irq,
  input  logic              dma_set,
  input  logic              dma_clr,
  output logic              dma_req
);
  localparam int DEPTH = fifo_depth(CHAN_ID);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              flush, pop, push, ovf_evt, udf_evt, ready_cond;
  logic              full, empty, of_st, uf_st, rdy_flag, err_flag, armed;
  logic [CNT_W-1:0]  cnt;
  logic [THR_W-1:0]  thr;
  logic [DATA_W-1:0] head;
  logic [1:0]        ie;
  logic              unused_cfg;

  assign unused_cfg = ^{ctl_wdata[31:16], ctl_wdata[7:1],
                        int_wdata[31:18], int_wdata[15:2]};

  // event qualification: flush dominates, a pop frees room for a push
  always_comb begin
    flush      = ctl_wr & ctl_wdata[FLUSH_BIT];
    pop        = rd_en & ~empty & ~flush;
    udf_evt    = rd_en & empty & ~flush;
    push       = smp_valid & ~flush & (~full | pop);
    ovf_evt    = smp_valid & ~flush & full & ~pop;
    ready_cond = ~empty & (THR_W'(cnt) >= thr);
  end

  smpf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wdata(smp_data), .head(head), .cnt(cnt), .full(full), .empty(empty)
  );

  smpf_stat #(.DATA_W(DATA_W), .THR_W(THR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cfg_wr(ctl_wr),
    .cfg_thr(ctl_wdata[THR_MSB:THR_LSB]), .flush(flush),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt), .rd_en(rd_en), .pop(pop),
    .head(head), .thr(thr), .of_st(of_st), .uf_st(uf_st), .rd_data(rd_data)
  );

  smpf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ready_cond(ready_cond),
    .err_evt(ovf_evt | udf_evt),
    .clr_rdy(int_wr & int_wdata[RDY_FLG]),
    .clr_err(int_wr & int_wdata[ERR_FLG]),
    .ie_wr(int_wr), .ie_val({int_wdata[ERR_IE], int_wdata[RDY_IE]}),
    .arm_set(dma_set), .arm_clr(dma_clr),
    .rdy_flag(rdy_flag), .err_flag(err_flag), .ie(ie), .armed(armed)
  );

  always_comb begin
    ctl_rdata                   = '0;
    ctl_rdata[CNT_MSB:CNT_LSB]  = CNT_FW'(cnt);
    ctl_rdata[UF_BIT]           = uf_st;
    ctl_rdata[OF_BIT]           = of_st;
    ctl_rdata[THR_MSB:THR_LSB]  = thr;
    int_rdata                   = '0;
    int_rdata[ERR_FLG]          = err_flag;
    int_rdata[RDY_FLG]          = rdy_flag;
    int_rdata[ERR_IE]           = ie[1];
    int_rdata[RDY_IE]           = ie[0];
  end

  assign irq     = (err_flag & ie[1]) | (rdy_flag & ie[0]);
  assign dma_req = armed & ready_cond;
endmodule

// File: rtl/smp_fifo_chk.sv
module smp_fifo_chk #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              rd_en,
  input logic              flush,
  input logic [CNT_W-1:0]  cnt,
  input logic [7:0]        thr,
  input logic              of_st,
  input logic              uf_st,
  input logic              rdy_flag,
  input logic [DATA_W-1:0] rd_data
);
  assert_cnt_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !rd_en && !flush && int'(cnt) == DEPTH)
      |=> (of_st && int'(cnt) == DEPTH));

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !flush && cnt == '0) |=> (uf_st && rd_data == '0));

  assert_ready_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && int'(cnt) >= int'(thr)) |=> rdy_flag);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !of_st && !uf_st));

  assert_full_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rd_en && !flush && int'(cnt) == DEPTH)
      |=> (int'(cnt) == DEPTH && $stable(of_st)));
endmodule

bind smp_fifo smp_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rd_en(rd_en),
  .flush(flush), .cnt(cnt), .thr(thr), .of_st(of_st), .uf_st(uf_st),
  .rdy_flag(rdy_flag), .rd_data(rd_data)
);

// File: tb/smp_fifo_bench.sv
module smp_fifo_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, rd_en, ctl_wr, int_wr, dma_set, dma_clr;
  logic [DW-1:0] smp_data;
  logic [31:0] ctl_wdata, int_wdata;

  logic [DW-1:0] rd_n, rd_w;
  logic [31:0]   ctl_n, ctl_w, int_n, int_w;
  logic          irq_n, irq_w, dma_n, dma_w;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  smp_fifo #(.CHAN_ID(2), .DATA_W(DW)) u_smp_fifo (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .rd_data(rd_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_n), .int_wr(int_wr), .int_wdata(int_wdata),
    .int_rdata(int_n), .irq(irq_n), .dma_set(dma_set), .dma_clr(dma_clr),
    .dma_req(dma_n));

  smp_fifo #(.CHAN_ID(0), .DATA_W(DW)) u_smp_fifo_wide (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .rd_data(rd_w), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_w), .int_wr(int_wr), .int_wdata(int_wdata),
    .int_rdata(int_w), .irq(irq_w), .dma_set(dma_set), .dma_clr(dma_clr),
    .dma_req(dma_w));

  // reference model state: index 0 = 8 deep, index 1 = 64 deep
  int          mq_n[$];
  int          mq_w[$];
  logic        m_of[2], m_uf[2], m_rdy[2], m_err[2];
  logic [DW-1:0] m_rd[2];
  logic [7:0]  m_thr;
  logic [1:0]  m_ie;
  logic        m_arm;

  function automatic bit ready(input int sz, input logic [7:0] t);
    return (sz > 0) && (sz >= int'(t));
  endfunction

  task automatic adv(ref int q[$], input int dep, input int k, input bit cnd);
    bit popd = 0;
    bit ev   = 0;
    int sz   = q.size();
    if (ctl_wr && ctl_wdata[0]) begin
      q.delete();
      m_of[k] = 1'b0;
      m_uf[k] = 1'b0;
      if (rd_en) m_rd[k] = '0;
    end else begin
      if (rd_en) begin
        if (sz > 0) begin
          m_rd[k] = DW'(q.pop_front());
          popd = 1;
        end else begin
          m_rd[k] = '0;
          m_uf[k] = 1'b1;
          ev = 1;
        end
      end
      if (smp_valid) begin
        if (sz < dep || popd) q.push_back(int'(smp_data));
        else begin
          m_of[k] = 1'b1;
          ev = 1;
        end
      end
    end
    m_rdy[k] = cnd | (m_rdy[k] & ~(int_wr & int_wdata[16]));
    m_err[k] = ev  | (m_err[k] & ~(int_wr & int_wdata[17]));
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_n.delete();
      mq_w.delete();
      for (int k = 0; k < 2; k++) begin
        m_of[k] = 0; m_uf[k] = 0; m_rdy[k] = 0; m_err[k] = 0; m_rd[k] = '0;
      end
      m_thr = 8'd1;
      m_ie  = 2'b00;
      m_arm = 1'b0;
    end else begin
      bit c0, c1;
      c0 = ready(mq_n.size(), m_thr);
      c1 = ready(mq_w.size(), m_thr);
      adv(mq_n, 8, 0, c0);
      adv(mq_w, 64, 1, c1);
      if (ctl_wr) m_thr = ctl_wdata[15:8];
      if (int_wr) m_ie = int_wdata[1:0];
      if (dma_set)      m_arm = 1'b1;
      else if (dma_clr) m_arm = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_inst(input int k, input int sz, input logic [31:0] ctl,
                          input logic [31:0] iw, input logic [DW-1:0] rd,
                          input logic irq, input logic dma);
    chk("R1 R11", "count",     32'(ctl[30:24]), 32'(sz));
    chk("R2",  "threshold",    32'(ctl[15:8]),  32'(m_thr));
    chk("R3",  "overflow",     32'(ctl[17]),    32'(m_of[k]));
    chk("R4",  "underflow",    32'(ctl[18]),    32'(m_uf[k]));
    chk("R10", "flush bit",    32'(ctl[0]),     32'd0);
    chk("R5",  "rd_data",      32'(rd),         32'(m_rd[k]));
    chk("R6",  "ready flag",   32'(iw[16]),     32'(m_rdy[k]));
    chk("R7",  "error flag",   32'(iw[17]),     32'(m_err[k]));
    chk("R8",  "enables",      32'(iw[1:0]),    32'(m_ie));
    chk("R8",  "irq",          32'(irq),
        32'((m_err[k] & m_ie[1]) | (m_rdy[k] & m_ie[0])));
    chk("R9",  "dma_req",      32'(dma),        32'(m_arm & ready(sz, m_thr)));
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp_inst(0, mq_n.size(), ctl_n, int_n, rd_n, irq_n, dma_n);
      cmp_inst(1, mq_w.size(), ctl_w, int_w, rd_w, irq_w, dma_w);
    end
  end

  logic [DW-1:0] sd = 16'h0101;

  task automatic step(input bit v, input bit rd, input bit cw, input logic [31:0] cwd,
                      input bit iw, input logic [31:0] iwd, input bit ds, input bit dc);
    smp_valid = v;  smp_data = sd;  rd_en = rd;
    ctl_wr = cw;    ctl_wdata = cwd;
    int_wr = iw;    int_wdata = iwd;
    dma_set = ds;   dma_clr = dc;
    if (v) sd = sd + 16'd37;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    smp_valid = 0; smp_data = '0; rd_en = 0; ctl_wr = 0; ctl_wdata = '0;
    int_wr = 0; int_wdata = '0; dma_set = 0; dma_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                                   // reset state, R2 threshold 1
    // R5: order
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // R4: read past empty, error flag R7
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // R10 flush, R8 enables
    step(0, 0, 1, 32'h0000_0101, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 32'h3, 0, 0);
    // fill narrow exactly, then R12 swap at full
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R12", "count after swap at full", 32'(ctl_n[30:24]), 32'd8);
    chk("R12", "no overflow after swap",   32'(ctl_n[17]),    32'd0);
    // R3 overflow on narrow, then on wide (R11)
    for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R11", "deep instance holds 64", 32'(ctl_w[30:24]), 32'd64);
    // R6 R7 clear while set conditions hold
    step(0, 0, 0, 0, 1, 32'h0003_0003, 0, 0);
    idle(1);
    // R9 arm, both, disarm
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    // drain past empty on both
    for (int i = 0; i < 70; i++) step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 32'h0003_0003, 0, 0);
    // R2 threshold 5, R6 ready edge
    step(0, 0, 1, 32'h0000_0500, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    idle(2);
    // R10 flush with same-cycle sample and read
    step(1, 1, 1, 32'h0000_0201, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 32'h0000_0001, 0, 0, 0, 0);  // threshold 0
    step(1, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit cw = ($urandom % 12) == 0;
      logic [31:0] cwd = {16'h0, 8'($urandom % 10), 7'h0, 1'(($urandom % 6) == 0)};
      bit iw = ($urandom % 16) == 0;
      logic [31:0] iwd = {14'h0, 2'($urandom), 14'h0, 2'($urandom)};
      step(1'(($urandom % 2) == 0), 1'(($urandom % 5) < 2), cw, cwd, iw, iwd,
           1'(($urandom % 16) == 0), 1'(($urandom % 16) == 0));
    end
    idle(2);
    finish_run();
  end
endmodule